// File: doc/BRIEF.md
# Dual-Lane PRBS Loopback Checker

This block tests a two-lane serial link by looping it back on itself. On the transmit side it produces one word per clock for each lane. After reset it sends a short run of fixed sync words. It then sends a continuous PRBS-7 stream. On the receive side, each of the two 8-bit lanes has its own aligner. The aligner finds the bit offset of the sync word within the incoming word stream. Once the sync word has been seen twice at the same offset, the aligner locks that offset.

When the lane's first non-sync word arrives, the lane starts its own reference generator from the same seed as the transmitter. From then on it compares every received word with the word it expects. The two lane results are combined by AND into one registered link-match bit. Any cycle in which the link is valid and that bit is low sets a sticky error flag and increments a saturating error counter. A separate clear input resets the flag and the counter without disturbing the lane lock. For self-test, a rising edge on the inject input flips one bit of one transmitted word.

Top module: `prbs_loop_checker`

## Requirements
- R1: After reset is released, both transmit ports carry SYNC_WORDS (default 4) copies of the sync word 0xBC. They then carry PRBS-7 words (x^7 + x^6 + 1, eight bits per clock, the first generated bit in bit 7, seed all ones), so the first PRBS word is 0x02. Transmit word k appears after the (k+1)-th clock edge following reset release.
- R2: A rising edge on err_inject inverts bit 0 of tx_lane0 for exactly one word, namely the word registered on that edge. Holding err_inject high flips no further words, and tx_lane1 is never flipped.
- R3: Each lane aligns to any bit offset from 0 to 7. At a non-zero offset, the earlier bits of a word sit in the low bits of one input word and the rest sit in the high bits of the next. A lane locks after two consecutive sync matches at the same offset and keeps the lock until reset.
- R4: After lock, a lane becomes valid at its first aligned word that is not the sync word. Its reference starts at the seed's first word. An error-free stream leaves link_match high.
- R5: link_match is the registered AND of both lanes' compare results. Take a lane with zero offset and zero delay whose input word m is corrupted. link_match is low only after clock edge m+1 and is high again after edge m+2.
- R6: A cycle in which both lanes are valid and link_match is low raises err_flag and adds one to err_count. This shows one clock after link_match falls. The flag stays set, and reset clears both the flag and the counter.
- R7: err_count stops at all ones and does not wrap.
- R8: err_clr clears err_flag and err_count on the next edge. The lanes keep their lock and link_match stays high.
- R9: No error is counted while either lane is still unaligned or not yet valid, even if that lane's words are wrong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| err_inject | input | 1 | Error insertion request, rising edge acts |
| err_clr | input | 1 | Synchronous clear of error flag and counter |
| rx_lane0 | input | W | Looped-back word stream, lane 0 |
| rx_lane1 | input | W | Looped-back word stream, lane 1 |
| tx_lane0 | output | W | Transmit word stream, lane 0 |
| tx_lane1 | output | W | Transmit word stream, lane 1 |
| link_match | output | 1 | Registered AND of lane compare results |
| err_flag | output | 1 | Sticky mismatch flag |
| err_count | output | ERR_W | Saturating mismatch counter |

## Verification
Timing is fixed for each result. A word that enters a zero-offset lane on edge m reaches the comparator on that edge. Its effect on link_match is visible after edge m+1, and its effect on err_count after edge m+2. A non-zero offset or an input delay of d words moves both results later by one and by d cycles respectively. Transmit word k is visible after edge k.

The bench applies each input half a period before the edge that samples it and reads the outputs half a period after. It places every expectation at the cycle these latencies give. Error totals are computed from the corrupted words whose compare cycle falls on or after the later of the two lanes' valid cycles.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

   // per-lane result handed from a lane checker to the link combiner
   typedef struct packed {
      logic valid;   // lane aligned and past its sync words
      logic eq;      // received word equals reference word this cycle
   } lane_res_t;

endpackage

// File: rtl/prbs_word_gen.sv
module prbs_word_gen #(
   parameter int ORDER  = 7,
   parameter int TAP_HI = 7,
   parameter int TAP_LO = 6,
   parameter int W      = 8,
   parameter logic [ORDER-1:0] SEED = '1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         advance,
   output logic [W-1:0] word
);

   if (TAP_HI > ORDER || TAP_LO >= TAP_HI || TAP_LO < 1) begin : g_bad_taps
      $error("prbs_word_gen: tap positions out of range");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("prbs_word_gen: seed must be non-zero");
   end

   logic [ORDER-1:0] state_q;
   logic [ORDER-1:0] walk;
   logic             fb;

   // W serial steps per clock; first generated bit lands in the MSB
   always_comb begin
      walk = state_q;
      fb   = 1'b0;
      word = '0;
      for (int b = W - 1; b >= 0; b--) begin
         fb      = walk[TAP_HI-1] ^ walk[TAP_LO-1];
         walk    = {walk[ORDER-2:0], fb};
         word[b] = fb;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)          state_q <= SEED;
      else if (advance) state_q <= walk;
   end

endmodule

// File: rtl/lane_aligner.sv
module lane_aligner #(
   parameter int W = 8,
   parameter logic [W-1:0] SYNC = 8'hBC
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] rx,
   output logic [W-1:0] word,
   output logic         word_ok
);

   localparam int KW = (W > 1) ? $clog2(W) : 1;

   logic [W-1:0]   prev_q;
   logic [2*W-1:0] pair;
   logic [W-1:0]   hit;
   logic           any_hit;
   logic [KW-1:0]  first_k;
   logic           cand_q, locked_q, ok_q;
   logic [KW-1:0]  cand_k_q, lock_k_q;
   logic [W-1:0]   word_q;

   assign pair = {prev_q, rx};

   // one comparator per bit offset
   for (genvar k = 0; k < W; k++) begin : g_rot
      assign hit[k] = (pair[k +: W] == SYNC);
   end

   always_comb begin
      any_hit = |hit;
      first_k = '0;
      for (int k = W - 1; k >= 0; k--) begin
         if (hit[k]) first_k = KW'(k);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q   <= '0;
         cand_q   <= 1'b0;
         cand_k_q <= '0;
         locked_q <= 1'b0;
         lock_k_q <= '0;
         word_q   <= '0;
         ok_q     <= 1'b0;
      end else begin
         prev_q <= rx;
         word_q <= pair[lock_k_q +: W];
         ok_q   <= locked_q;
         if (!locked_q) begin
            if (cand_q && hit[cand_k_q]) begin
               locked_q <= 1'b1;
               lock_k_q <= cand_k_q;
            end else begin
               cand_q   <= any_hit;
               cand_k_q <= first_k;
            end
         end
      end
   end

   assign word    = word_q;
   assign word_ok = ok_q;

endmodule

// File: rtl/lane_checker.sv
module lane_checker
   import prbs_chk_pkg::*;
#(
   parameter int W      = 8,
   parameter logic [W-1:0] SYNC = 8'hBC,
   parameter int ORDER  = 7,
   parameter int TAP_HI = 7,
   parameter int TAP_LO = 6,
   parameter logic [ORDER-1:0] SEED = '1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] rx,
   output lane_res_t    res
);

   logic [W-1:0] al_word;
   logic         al_ok;
   logic [W-1:0] ref_word;
   logic         started_q;
   logic         valid;

   lane_aligner #(.W(W), .SYNC(SYNC)) u_align (
      .clk     (clk),
      .rst     (rst),
      .rx      (rx),
      .word    (al_word),
      .word_ok (al_ok)
   );

   assign valid = started_q | (al_ok && (al_word != SYNC));

   prbs_word_gen #(
      .ORDER(ORDER), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .W(W), .SEED(SEED)
   ) u_ref (
      .clk     (clk),
      .rst     (rst),
      .advance (valid),
      .word    (ref_word)
   );

   always_ff @(posedge clk) begin
      if (rst) started_q <= 1'b0;
      else if (valid) started_q <= 1'b1;
   end

   assign res.valid = valid;
   assign res.eq    = valid && (al_word == ref_word);

endmodule

// File: rtl/prbs_loop_checker.sv
module prbs_loop_checker
   import prbs_chk_pkg::*;
#(
   parameter int W          = 8,
   parameter logic [W-1:0] SYNC = 8'hBC,
   parameter int SYNC_WORDS = 4,
   parameter int ORDER      = 7,
   parameter int TAP_HI     = 7,
   parameter int TAP_LO     = 6,
   parameter logic [ORDER-1:0] SEED = '1,
   parameter int ERR_W      = 16,
   parameter int INJ_LANE   = 0,
   parameter int INJ_BIT    = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             err_inject,
   input  logic             err_clr,
   input  logic [W-1:0]     rx_lane0,
   input  logic [W-1:0]     rx_lane1,
   output logic [W-1:0]     tx_lane0,
   output logic [W-1:0]     tx_lane1,
   output logic             link_match,
   output logic             err_flag,
   output logic [ERR_W-1:0] err_count
);

   localparam int LANES = 2;
   localparam int CW    = $clog2(SYNC_WORDS + 1);
   localparam logic [W-1:0] FLIP = W'(1) << INJ_BIT;

   if (SYNC_WORDS < 3) begin : g_bad_sync
      $error("prbs_loop_checker: SYNC_WORDS must be at least 3");
   end
   if (INJ_LANE < 0 || INJ_LANE >= LANES || INJ_BIT < 0 || INJ_BIT >= W) begin : g_bad_inj
      $error("prbs_loop_checker: injection lane or bit out of range");
   end
   if (ERR_W < 2) begin : g_bad_cnt
      $error("prbs_loop_checker: ERR_W too small");
   end

   // ---------------- transmit side ----------------
   logic [CW-1:0] sync_cnt_q;
   logic          tx_run;
   logic [W-1:0]  tx_prbs, tx_word;
   logic          inj_q, inj_pulse;
   logic [W-1:0]  lane_flip [LANES];
   logic [W-1:0]  tx_q      [LANES];

   assign tx_run = (sync_cnt_q == CW'(SYNC_WORDS));

   prbs_word_gen #(
      .ORDER(ORDER), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .W(W), .SEED(SEED)
   ) u_tx_gen (
      .clk     (clk),
      .rst     (rst),
      .advance (tx_run),
      .word    (tx_prbs)
   );

   assign tx_word   = tx_run ? tx_prbs : SYNC;
   assign inj_pulse = err_inject & ~inj_q;

   for (genvar l = 0; l < LANES; l++) begin : g_flip
      if (l == INJ_LANE) begin : g_hit
         assign lane_flip[l] = inj_pulse ? FLIP : '0;
      end else begin : g_pass
         assign lane_flip[l] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_cnt_q <= '0;
         inj_q      <= 1'b0;
         for (int l = 0; l < LANES; l++) tx_q[l] <= '0;
      end else begin
         if (!tx_run) sync_cnt_q <= sync_cnt_q + 1'b1;
         inj_q <= err_inject;
         for (int l = 0; l < LANES; l++) tx_q[l] <= tx_word ^ lane_flip[l];
      end
   end

   assign tx_lane0 = tx_q[0];
   assign tx_lane1 = tx_q[1];

   // ---------------- receive side ----------------
   logic [W-1:0]     rx_arr [LANES];
   lane_res_t        res    [LANES];
   logic [LANES-1:0] lane_v, lane_e;

   assign rx_arr[0] = rx_lane0;
   assign rx_arr[1] = rx_lane1;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      lane_checker #(
         .W(W), .SYNC(SYNC), .ORDER(ORDER), .TAP_HI(TAP_HI),
         .TAP_LO(TAP_LO), .SEED(SEED)
      ) u_chk (
         .clk (clk),
         .rst (rst),
         .rx  (rx_arr[l]),
         .res (res[l])
      );
      assign lane_v[l] = res[l].valid;
      assign lane_e[l] = res[l].eq;
   end

   logic             link_valid_q, link_match_q, err_flag_q;
   logic [ERR_W-1:0] err_cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         link_valid_q <= 1'b0;
         link_match_q <= 1'b0;
      end else begin
         link_valid_q <= &lane_v;
         link_match_q <= &lane_e;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || err_clr) begin
         err_flag_q <= 1'b0;
         err_cnt_q  <= '0;
      end else if (link_valid_q && !link_match_q) begin
         err_flag_q <= 1'b1;
         if (err_cnt_q != '1) err_cnt_q <= err_cnt_q + 1'b1;
      end
   end

   assign link_match = link_match_q;
   assign err_flag   = err_flag_q;
   assign err_count  = err_cnt_q;

endmodule

// File: rtl/prbs_loop_checker_sva.sv
module prbs_loop_checker_sva #(
   parameter int W     = 8,
   parameter int ERR_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             err_clr,
   input logic [W-1:0]     tx_lane0,
   input logic [W-1:0]     tx_lane1,
   input logic             link_match,
   input logic             link_valid,
   input logic             err_flag,
   input logic [ERR_W-1:0] err_count
);

   // lanes differ in at most one bit (the injected one)
   assert_flip_single_R2: assert property (@(posedge clk) disable iff (rst)
      $countones(tx_lane0 ^ tx_lane1) <= 1);

   // an injected difference lasts a single word
   assert_flip_once_R2: assert property (@(posedge clk) disable iff (rst)
      (tx_lane0 != tx_lane1) |=> (tx_lane0 == tx_lane1));

   // a match is only reported on a valid link
   assert_match_valid_R5: assert property (@(posedge clk) disable iff (rst)
      link_match |-> link_valid);

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (err_flag && !err_clr) |=> err_flag);

   assert_flag_tracks_count_R6: assert property (@(posedge clk) disable iff (rst)
      err_flag == (err_count != '0));

   assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
      !err_clr |=> (err_count == $past(err_count)) ||
                   (err_count == $past(err_count) + 1'b1));

   assert_count_saturate_R7: assert property (@(posedge clk) disable iff (rst)
      ((err_count == '1) && !err_clr) |=> (err_count == '1));

   assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      err_clr |=> ((err_count == '0) && !err_flag));

endmodule

bind prbs_loop_checker prbs_loop_checker_sva #(.W(W), .ERR_W(ERR_W)) u_sva (
   .clk        (clk),
   .rst        (rst),
   .err_clr    (err_clr),
   .tx_lane0   (tx_lane0),
   .tx_lane1   (tx_lane1),
   .link_match (link_match),
   .link_valid (link_valid_q),
   .err_flag   (err_flag),
   .err_count  (err_count)
);

// File: tb/prbs_loop_checker_test.sv
`timescale 1ns/1ps
module prbs_loop_checker_test;

   localparam int ERR_W = 6;
   localparam int SAT   = (1 << ERR_W) - 1;
   localparam int MAXW  = 256;
   localparam int NSYNC = 4;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             err_inject = 1'b0;
   logic             err_clr = 1'b0;
   logic [7:0]       rx_lane0 = '0;
   logic [7:0]       rx_lane1 = '0;
   logic [7:0]       tx_lane0, tx_lane1;
   logic             link_match, err_flag;
   logic [ERR_W-1:0] err_count;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;

   logic [7:0] txw [MAXW];
   bit         cor [2][MAXW];

   always #2 clk = ~clk;

   prbs_loop_checker #(.ERR_W(ERR_W)) uut (
      .clk(clk), .rst(rst), .err_inject(err_inject), .err_clr(err_clr),
      .rx_lane0(rx_lane0), .rx_lane1(rx_lane1),
      .tx_lane0(tx_lane0), .tx_lane1(tx_lane1),
      .link_match(link_match), .err_flag(err_flag), .err_count(err_count)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
      end
   endtask

   // sync words, then x^7+x^6+1 from all-ones, MSB first
   task automatic build_tx();
      logic [6:0] st;
      logic [7:0] w;
      logic       fb;
      st = 7'h7F;
      for (int i = 0; i < MAXW; i++) begin
         if (i < NSYNC) txw[i] = 8'hBC;
         else begin
            for (int b = 7; b >= 0; b--) begin
               fb   = st[6] ^ st[5];
               st   = {st[5:0], fb};
               w[b] = fb;
            end
            txw[i] = w;
         end
      end
   endtask

   task automatic clear_cor();
      for (int l = 0; l < 2; l++)
         for (int i = 0; i < MAXW; i++) cor[l][i] = 1'b0;
   endtask

   function automatic logic [7:0] lane_word(int lane, int idx);
      logic [7:0] w;
      if (idx < 0 || idx >= MAXW) return 8'h00;
      w = txw[idx];
      if (cor[lane][idx]) w[idx % 8] = ~w[idx % 8];
      return w;
   endfunction

   // bit stream delayed by s bits: earlier word's tail in the low bits
   function automatic logic [7:0] rx_word(int lane, int t, int s, int d);
      logic [15:0] pair;
      pair = {lane_word(lane, t - 1 - d), lane_word(lane, t - d)};
      pair = pair >> s;
      return pair[7:0];
   endfunction

   task automatic run_phase(input int s0, input int s1, input int d0, input int d1,
                            input int n, input int inj_at, input int clr_at,
                            input int dir_m, input string cnt_req);
      int  lat0, lat1, vb, c, raw, expc;
      bit  hitc [MAXW + 16];
      logic [7:0] e0;
      rst = 1'b1; err_inject = 1'b0; err_clr = 1'b0;
      rx_lane0 = '0; rx_lane1 = '0;
      repeat (3) @(negedge clk);
      // reset state
      chk(link_match == 1'b0, "R5 reset", int'(link_match), 0);
      chk(err_count == '0, "R6 reset count", int'(err_count), 0);
      chk(err_flag == 1'b0, "R6 reset flag", int'(err_flag), 0);
      chk(tx_lane0 == 8'h00, "R1 reset tx", int'(tx_lane0), 0);
      rst = 1'b0;
      for (int t = 0; t < n; t++) begin
         rx_lane0   = rx_word(0, t, s0, d0);
         rx_lane1   = rx_word(1, t, s1, d1);
         err_inject = (inj_at >= 0 && t >= inj_at && t < inj_at + 3);
         err_clr    = (t == clr_at);
         @(negedge clk);
         e0 = txw[t] ^ ((t == inj_at) ? 8'h01 : 8'h00);
         if (inj_at >= 0 && t >= inj_at && t < inj_at + 3)
            chk(tx_lane0 == e0, "R2 tx_lane0", int'(tx_lane0), int'(e0));
         else
            chk(tx_lane0 == e0, "R1 tx_lane0", int'(tx_lane0), int'(e0));
         chk(tx_lane1 == txw[t], "R1 tx_lane1", int'(tx_lane1), int'(txw[t]));
         if (t == clr_at) begin
            chk(err_count == '0, "R8 count cleared", int'(err_count), 0);
            chk(err_flag == 1'b0, "R8 flag cleared", int'(err_flag), 0);
         end
         if (dir_m >= 0) begin
            if (t == dir_m)
               chk(link_match == 1'b1, "R5 before drop", int'(link_match), 1);
            if (t == dir_m + 1) begin
               chk(link_match == 1'b0, "R5 drop", int'(link_match), 0);
               chk(err_count == '0, "R6 not yet counted", int'(err_count), 0);
            end
            if (t == dir_m + 2) begin
               chk(link_match == 1'b1, "R5 recover", int'(link_match), 1);
               chk(err_count == ERR_W'(1), "R6 counted", int'(err_count), 1);
               chk(err_flag == 1'b1, "R6 flag", int'(err_flag), 1);
            end
         end
      end
      err_inject = 1'b0; err_clr = 1'b0;
      // expected errors: compare cycles at or after both lanes are valid
      lat0 = d0 + ((s0 != 0) ? 1 : 0);
      lat1 = d1 + ((s1 != 0) ? 1 : 0);
      vb   = NSYNC + ((lat0 > lat1) ? lat0 : lat1);
      for (int i = 0; i < MAXW + 16; i++) hitc[i] = 1'b0;
      for (int m = 0; m < MAXW; m++) begin
         if (cor[0][m]) begin
            c = m + lat0;
            if (c >= vb && (clr_at < 0 || c + 2 > clr_at)) hitc[c] = 1'b1;
         end
         if (cor[1][m]) begin
            c = m + lat1;
            if (c >= vb && (clr_at < 0 || c + 2 > clr_at)) hitc[c] = 1'b1;
         end
      end
      raw = 0;
      for (int i = 0; i < MAXW + 16; i++) if (hitc[i]) raw++;
      expc = (raw > SAT) ? SAT : raw;
      chk(int'(err_count) == expc, cnt_req, int'(err_count), expc);
      chk(err_flag == (expc > 0), "R6 flag end", int'(err_flag), int'(expc > 0));
      chk(link_match == 1'b1, "R4 link_match end", int'(link_match), 1);
   endtask

   initial begin
      int unsigned sd;
      int s0, d0, d1, nc, ia;
      sd = $urandom(32'd4711);
      build_tx();
      chk(txw[NSYNC] == 8'h02, "R1 first PRBS word model", int'(txw[NSYNC]), 2);

      // directed: zero offsets, one corrupt word, exact timing
      clear_cor();
      cor[0][20] = 1'b1;
      run_phase(0, 0, 0, 0, 40, -1, -1, 20, "R5 single error count");

      // R9: lane 1 late, early lane 0 error ignored; injection press held
      clear_cor();
      cor[0][6]  = 1'b1;
      cor[1][40] = 1'b1;
      run_phase(0, 3, 0, 7, 70, 15, -1, -1, "R9 count ignores unaligned period");

      // R3: every lane-1 offset, random lane-0 offset, delays and errors
      for (int p = 0; p < 8; p++) begin
         clear_cor();
         s0 = int'($urandom % 8);
         d0 = int'($urandom % 4);
         d1 = int'($urandom % 4);
         nc = int'($urandom % 4);
         for (int j = 0; j < nc; j++) cor[$urandom % 2][30 + 12 * j] = 1'b1;
         ia = ($urandom % 2 == 0) ? -1 : int'(10 + $urandom % 50);
         run_phase(s0, p, d0, d1, 90, ia, -1, -1, "R3 count after alignment");
      end

      // R7: long error burst saturates the counter
      clear_cor();
      for (int m = 20; m < 100; m++) cor[1][m] = 1'b1;
      run_phase(0, 5, 0, 0, 115, -1, -1, -1, "R7 saturated count");

      // R8: same burst, cleared afterwards, lock kept
      run_phase(0, 5, 0, 0, 130, -1, 110, -1, "R8 count after clear");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule